// File: doc/BRIEF.md
# Line-21 Closed Caption Inserter

This block writes a caption waveform into the digital luma stream of a 525-line interlaced encoder. Each caption line carries a seven-cycle clock run-in, a three-bit start pattern and two seven-bit characters, each sent least significant bit first with an odd parity bit added in bit 7. Captions go only on line 21 of field one and line 284 of field two. Each of the two lines has its own enable. All other lines, and the parts of a caption line outside the caption window, pass the upstream luma through with one register of delay.

The video timing generator supplies the line number, the horizontal pixel count and a field flag. A host writes the characters for each field through a small register window. An interrupt rises at the end of every caption line that was filled, so the host knows when to write the next pair. If no new pair has been written for a field since its last insertion, the null pair (two bytes of value 0x80) is sent instead.

Top module: `cc_inserter`

## Requirements
- R1: Only line 21 with `fieldTwo`=0 and line 284 with `fieldTwo`=1 are ever modified; on every other line `lumaOut` equals `lumaIn` from the previous clock.
- R2: Control register address 0 holds the enables: bit 0 enables field one (line 21), bit 1 enables field two (line 284). A disabled caption line passes `lumaIn` through and raises no interrupt.
- R3: On an enabled caption line the window starts at `hCount`=240 and lasts 26 bit periods of 32 clocks. The first 7 periods are run-in, where sample phase p (0..31) gives level 16+6*t with t=p for p<16 and t=31-p otherwise. Outside the window `lumaIn` passes through one clock late.
- R4: Periods 7, 8 and 9 of the window carry the start bits 0, 0, 1. A bit of 0 is sent at level 16 for the whole period and a bit of 1 at level 106.
- R5: Periods 10..25 carry the first character and then the second, least significant bit first. Field one's characters are written at addresses 1 and 2, field two's at 3 and 4. Only bits 6:0 of the written data are kept, and the block sets bit 7 so that each byte has an odd number of ones.
- R6: If a field's second-character register (address 2 or 4) has not been written since that field's last insertion, the bytes 0x80, 0x80 are sent. Each insertion consumes the written pair.
- R7: `ccIrq` rises on the clock after `hCount`=1715 of a caption line that carried an insertion.
- R8: `ccIrq` stays high until a write to address 0 with data bit 7 set, and is low on the clock after that write.
- R9: When an interrupt set and an acknowledge write fall in the same clock, `ccIrq` ends high.
- R10: While `lines625` is high, nothing is inserted and no interrupt is raised.
- R11: After reset `lumaOut` and `ccIrq` are 0, both enables are off and neither field has a pending pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lines625 | input | 1 | High when the timing runs in 625-line format |
| fieldTwo | input | 1 | High during the second field |
| lineNum | input | 10 | Current line number in the frame |
| hCount | input | 11 | Pixel count within the line |
| lumaIn | input | 8 | Upstream luma sample |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | 3 | Host register address |
| wrData | input | 8 | Host write data |
| lumaOut | output | 8 | Luma with captions inserted, one clock late |
| ccIrq | output | 1 | Caption refill interrupt |

## Verification
The interrupt can be set and acknowledged in the same clock: the end-of-line set at `hCount`=1715 and a host write to address 0 with bit 7 high. The bench provokes this by putting the acknowledge write on the last pixel of a filled caption line. It then expects `ccIrq` high, because the set wins. It also checks that an acknowledge on any other clock clears the flag. Every caption line is swept pixel by pixel, and each sample is compared with a level computed from the run-in formula, the start pattern and the parity-extended characters.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int BIT_LOG2   = 5;
  localparam int RUNIN_CYC  = 7;
  localparam int START_BITS = 3;
  localparam int DATA_BITS  = 16;
  localparam int TOTAL_BITS = RUNIN_CYC + START_BITS + DATA_BITS;
  localparam int IDX_W      = $clog2(TOTAL_BITS);

  typedef struct packed {
    logic                load;
    logic                fieldSel;
    logic                emit;
    logic [BIT_LOG2-1:0] phase;
    logic [IDX_W-1:0]    bitIdx;
  } ccStrobe_t;
endpackage

// File: rtl/cc_hostregs.sv
module cc_hostregs #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        consume,
  output logic [1:0]        fieldEn,
  output logic              ackPulse,
  output logic [1:0][2*DATA_W-1:0] fieldWord
);
  localparam int CHAR_W = DATA_W - 1;
  localparam logic [DATA_W-1:0] NULL_BYTE = {1'b1, {CHAR_W{1'b0}}};

  logic ctrlWr;
  assign ctrlWr   = wrEn && (wrAddr == ADDR_W'(0));
  assign ackPulse = ctrlWr && wrData[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fieldEn <= '0;
    else if (ctrlWr) fieldEn <= wrData[1:0];
  end

  for (genvar f = 0; f < 2; f++) begin : g_field
    logic [CHAR_W-1:0] charLo, charHi;
    logic              pending;
    logic              wrLo, wrHi;
    assign wrLo = wrEn && (wrAddr == ADDR_W'(1 + 2*f));
    assign wrHi = wrEn && (wrAddr == ADDR_W'(2 + 2*f));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        charLo  <= '0;
        charHi  <= '0;
        pending <= 1'b0;
      end else begin
        if (wrLo) charLo <= wrData[CHAR_W-1:0];
        if (wrHi) charHi <= wrData[CHAR_W-1:0];
        if (wrHi) pending <= 1'b1;
        else if (consume[f]) pending <= 1'b0;
      end
    end

    assign fieldWord[f] = pending ? {~^charHi, charHi, ~^charLo, charLo}
                                  : {NULL_BYTE, NULL_BYTE};
  end
endmodule

// File: rtl/cc_ctrl.sv
module cc_ctrl
  import cc_pkg::*;
#(
  parameter int LINE_W      = 10,
  parameter int HC_W        = 11,
  parameter int LINE_F1     = 21,
  parameter int LINE_F2     = 284,
  parameter int START_H     = 240,
  parameter int LINE_LAST_H = 1715
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINE_W-1:0] lineNum,
  input  logic [HC_W-1:0]   hCount,
  input  logic              fieldTwo,
  input  logic              lines625,
  input  logic [1:0]        fieldEn,
  input  logic              ackPulse,
  output ccStrobe_t         strobe,
  output logic              ccIrq
);
  localparam int WINDOW = TOTAL_BITS << BIT_LOG2;
  localparam logic [LINE_W-1:0] L1 = LINE_W'(LINE_F1);
  localparam logic [LINE_W-1:0] L2 = LINE_W'(LINE_F2);
  localparam logic [HC_W-1:0] HSTART = HC_W'(START_H);
  localparam logic [HC_W-1:0] HLAST  = HC_W'(LINE_LAST_H);
  localparam logic [HC_W-1:0] HWIN   = HC_W'(WINDOW);

  logic onF1, onF2, capLine, lineEn, startHit, inWin, irqSet, armed;
  logic [HC_W-1:0] offset;

  assign onF1     = !fieldTwo && (lineNum == L1);
  assign onF2     = fieldTwo && (lineNum == L2);
  assign capLine  = !lines625 && (onF1 || onF2);
  assign lineEn   = !lines625 && ((onF1 && fieldEn[0]) || (onF2 && fieldEn[1]));
  assign offset   = hCount - HSTART;
  assign inWin    = (hCount >= HSTART) && (offset < HWIN);
  assign startHit = lineEn && (hCount == HSTART) && !armed;
  assign irqSet   = armed && capLine && (hCount == HLAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         armed <= 1'b0;
    else if (!capLine) armed <= 1'b0;
    else if (startHit) armed <= 1'b1;
    else if (irqSet)   armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         ccIrq <= 1'b0;
    else if (irqSet)   ccIrq <= 1'b1;
    else if (ackPulse) ccIrq <= 1'b0;
  end

  always_comb begin
    strobe.load     = startHit;
    strobe.fieldSel = fieldTwo;
    strobe.emit     = (startHit || armed) && inWin;
    strobe.phase    = offset[BIT_LOG2-1:0];
    strobe.bitIdx   = offset[BIT_LOG2 +: IDX_W];
  end
endmodule

// File: rtl/cc_datapath.sv
module cc_datapath
  import cc_pkg::*;
#(
  parameter int LUMA_W = 8,
  parameter int LO_LVL = 16,
  parameter int STEP   = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ccStrobe_t               strobe,
  input  logic [1:0][DATA_BITS-1:0] fieldWord,
  input  logic [LUMA_W-1:0]       lumaIn,
  output logic [LUMA_W-1:0]       lumaOut
);
  localparam int TRI_W      = BIT_LOG2 - 1;
  localparam int HI_LVL     = LO_LVL + STEP * ((1 << TRI_W) - 1);
  localparam int DATA_IDX_W = $clog2(DATA_BITS);

  logic [DATA_BITS-1:0] word;
  logic [TRI_W-1:0]     triVal;
  logic [IDX_W-1:0]     seq;
  logic [IDX_W-1:0]     dataIdx;
  logic                 bitVal;
  logic [LUMA_W-1:0]    level;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            word <= '0;
    else if (strobe.load) word <= fieldWord[strobe.fieldSel];
  end

  assign triVal  = strobe.phase[BIT_LOG2-1] ? ~strobe.phase[TRI_W-1:0]
                                            : strobe.phase[TRI_W-1:0];
  assign seq     = strobe.bitIdx - IDX_W'(RUNIN_CYC);
  assign dataIdx = seq - IDX_W'(START_BITS);

  always_comb begin
    if (seq < IDX_W'(START_BITS)) bitVal = (seq == IDX_W'(START_BITS - 1));
    else                          bitVal = word[dataIdx[DATA_IDX_W-1:0]];
    if (strobe.bitIdx < IDX_W'(RUNIN_CYC))
      level = LUMA_W'(LO_LVL) + LUMA_W'(STEP) * LUMA_W'(triVal);
    else
      level = bitVal ? LUMA_W'(HI_LVL) : LUMA_W'(LO_LVL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lumaOut <= '0;
    else       lumaOut <= strobe.emit ? level : lumaIn;
  end
endmodule

// File: rtl/cc_inserter.sv
module cc_inserter
  import cc_pkg::*;
#(
  parameter int LINE_W      = 10,
  parameter int HC_W        = 11,
  parameter int LUMA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int LINE_F1     = 21,
  parameter int LINE_F2     = 284,
  parameter int START_H     = 240,
  parameter int LINE_LAST_H = 1715,
  parameter int LO_LVL      = 16,
  parameter int STEP        = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lines625,
  input  logic              fieldTwo,
  input  logic [LINE_W-1:0] lineNum,
  input  logic [HC_W-1:0]   hCount,
  input  logic [LUMA_W-1:0] lumaIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  output logic [LUMA_W-1:0] lumaOut,
  output logic              ccIrq
);
  ccStrobe_t strobe;
  logic [1:0] fieldEn, consume;
  logic       ackPulse;
  logic [1:0][DATA_BITS-1:0] fieldWord;

  assign consume = {strobe.load && strobe.fieldSel, strobe.load && !strobe.fieldSel};

  cc_hostregs #(.ADDR_W(ADDR_W), .DATA_W(8)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .consume(consume), .fieldEn(fieldEn), .ackPulse(ackPulse),
    .fieldWord(fieldWord));

  cc_ctrl #(.LINE_W(LINE_W), .HC_W(HC_W), .LINE_F1(LINE_F1), .LINE_F2(LINE_F2),
            .START_H(START_H), .LINE_LAST_H(LINE_LAST_H)) u_ctrl (
    .clk(clk), .rstN(rstN), .lineNum(lineNum), .hCount(hCount),
    .fieldTwo(fieldTwo), .lines625(lines625), .fieldEn(fieldEn),
    .ackPulse(ackPulse), .strobe(strobe), .ccIrq(ccIrq));

  cc_datapath #(.LUMA_W(LUMA_W), .LO_LVL(LO_LVL), .STEP(STEP)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fieldWord(fieldWord),
    .lumaIn(lumaIn), .lumaOut(lumaOut));
endmodule

// File: rtl/cc_inserter_chk.sv
module cc_inserter_chk #(
  parameter int LINE_W      = 10,
  parameter int HC_W        = 11,
  parameter int LUMA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int LINE_F1     = 21,
  parameter int LINE_F2     = 284,
  parameter int START_H     = 240,
  parameter int LINE_LAST_H = 1715
) (
  input logic              clk,
  input logic              rstN,
  input logic              lines625,
  input logic              fieldTwo,
  input logic [LINE_W-1:0] lineNum,
  input logic [HC_W-1:0]   hCount,
  input logic [LUMA_W-1:0] lumaIn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [7:0]        wrData,
  input logic [LUMA_W-1:0] lumaOut,
  input logic              ccIrq
);
  logic capLine, ackWr;
  assign capLine = (!fieldTwo && lineNum == LINE_W'(LINE_F1)) ||
                   (fieldTwo && lineNum == LINE_W'(LINE_F2));
  assign ackWr = wrEn && (wrAddr == ADDR_W'(0)) && wrData[7];

  assert_passthru_R1: assert property (@(posedge clk) disable iff (!rstN)
    !capLine |=> lumaOut == $past(lumaIn));

  assert_before_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hCount < HC_W'(START_H)) |=> lumaOut == $past(lumaIn));

  assert_irq_at_line_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ccIrq) |-> $past(hCount) == HC_W'(LINE_LAST_H));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ackWr && hCount != HC_W'(LINE_LAST_H)) |=> !ccIrq);

  assert_irq_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ccIrq && !ackWr) |=> ccIrq);

  assert_625_pass_R10: assert property (@(posedge clk) disable iff (!rstN)
    lines625 |=> (lumaOut == $past(lumaIn)) && !$rose(ccIrq));
endmodule

bind cc_inserter cc_inserter_chk #(
  .LINE_W(LINE_W), .HC_W(HC_W), .LUMA_W(LUMA_W), .ADDR_W(ADDR_W),
  .LINE_F1(LINE_F1), .LINE_F2(LINE_F2), .START_H(START_H),
  .LINE_LAST_H(LINE_LAST_H)
) u_chk (
  .clk(clk), .rstN(rstN), .lines625(lines625), .fieldTwo(fieldTwo),
  .lineNum(lineNum), .hCount(hCount), .lumaIn(lumaIn), .wrEn(wrEn),
  .wrAddr(wrAddr), .wrData(wrData), .lumaOut(lumaOut), .ccIrq(ccIrq));

// File: tb/test_cc_inserter.sv
`timescale 1ns/1ps
module test_cc_inserter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lines625 = 1'b0, fieldTwo = 1'b0;
  logic [9:0]  lineNum = '0;
  logic [10:0] hCount = '0;
  logic [7:0]  lumaIn = '0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  lumaOut;
  logic        ccIrq;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cc_inserter i_cc_inserter (
    .clk(clk), .rstN(rstN), .lines625(lines625), .fieldTwo(fieldTwo),
    .lineNum(lineNum), .hCount(hCount), .lumaIn(lumaIn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .lumaOut(lumaOut), .ccIrq(ccIrq));

  function automatic logic [7:0] withParity(input logic [7:0] d);
    return {~^d[6:0], d[6:0]};
  endfunction

  function automatic logic [7:0] expLuma(input int h, input bit act, input logic [15:0] w);
    logic [7:0] inp;
    int off, b, p, t, s;
    bit bv;
    inp = 8'(h) ^ 8'h5A;
    if (!act || h < 240 || h >= 240 + 26*32) return inp;
    off = h - 240; b = off / 32; p = off % 32;
    if (b < 7) begin
      t = (p < 16) ? p : 31 - p;
      return 8'(16 + 6*t);
    end
    s = b - 7;
    bv = (s < 3) ? (s == 2) : w[s-3];
    return bv ? 8'd106 : 8'd16;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic sweepLine(input string req, input int ln, input bit f2, input bit l625,
                           input bit act, input logic [15:0] w,
                           input bit ackAtEnd, input logic [7:0] ctrlVal);
    for (int h = 0; h < 1716; h++) begin
      @(negedge clk);
      lineNum = 10'(ln); fieldTwo = f2; lines625 = l625;
      hCount = 11'(h); lumaIn = 8'(h) ^ 8'h5A;
      if (ackAtEnd && h == 1715) begin
        wrEn = 1'b1; wrAddr = 3'd0; wrData = ctrlVal;
      end
      @(posedge clk); #1;
      check(req, lumaOut, expLuma(h, act, w));
    end
    @(negedge clk);
    wrEn = 1'b0; lineNum = '0; hCount = '0; fieldTwo = 1'b0; lines625 = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [15:0] wA, wB;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 lumaOut", lumaOut, 0);
    check("R11 irq", ccIrq, 0);
    rstN = 1'b1;
    // R2: disabled caption line passes through, no irq
    sweepLine("R2", 21, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0);
    check("R2 irq", ccIrq, 0);
    // R3 R4 R5: field one with characters
    hostWrite(3'd0, 8'h01);
    hostWrite(3'd1, 8'h41);
    hostWrite(3'd2, 8'h42);
    wA = {withParity(8'h42), withParity(8'h41)};
    check("R5 parity", wA, 16'hC2C1);
    sweepLine("R3 R4 R5", 21, 1'b0, 1'b0, 1'b1, wA, 1'b0, 8'h0);
    check("R7 irq", ccIrq, 1);
    // R6: no new write, null pair
    sweepLine("R6", 21, 1'b0, 1'b0, 1'b1, 16'h8080, 1'b0, 8'h0);
    check("R8 irq held", ccIrq, 1);
    hostWrite(3'd0, 8'h81);
    check("R8 ack", ccIrq, 0);
    // R1: wrong field / wrong line
    sweepLine("R1 field", 21, 1'b1, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0);
    sweepLine("R1 line", 20, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0);
    check("R1 irq", ccIrq, 0);
    // R2 R5: field two only, bit 7 of write ignored
    hostWrite(3'd0, 8'h02);
    hostWrite(3'd3, 8'hFF);
    hostWrite(3'd4, 8'h01);
    wB = {withParity(8'h01), withParity(8'hFF)};
    check("R5 word", wB, 16'h017F);
    sweepLine("R2 f1 off", 21, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0);
    sweepLine("R5 f2", 284, 1'b1, 1'b0, 1'b1, wB, 1'b0, 8'h0);
    check("R7 irq f2", ccIrq, 1);
    hostWrite(3'd0, 8'h83);
    check("R8 ack2", ccIrq, 0);
    // R10: 625-line mode inserts nothing
    sweepLine("R10", 21, 1'b0, 1'b1, 1'b0, 16'h0, 1'b0, 8'h0);
    check("R10 irq", ccIrq, 0);
    // R9: set and ack in same clock
    sweepLine("R9 line", 21, 1'b0, 1'b0, 1'b1, 16'h8080, 1'b1, 8'h83);
    check("R9 set wins", ccIrq, 1);
    hostWrite(3'd0, 8'h83);
    check("R8 ack3", ccIrq, 0);
    done = 1'b1;
    summary();
  end
endmodule